// File: doc/BRIEF.md
# Rotating Multi-LUN Page Write Scheduler

This block sits between a sample FIFO and a flash device that holds several independent logical units (LUNs), each of which can take a new page while the others are still programming. It sends each page to the next LUN in a fixed rotation. For every page it selects the target LUN and issues a load-begin command. It then issues the page address bytes and streams the page payload from the FIFO. It closes the page with a program command and moves the rotation on. The program time of any one LUN is therefore hidden behind the loading of the others. By the time the rotation comes back to a LUN, that LUN should be idle again.

A controller asks for each page by holding `page_req`. The scheduler answers with a one-cycle `page_done` once the program command has gone out. If `page_req` is still high, the next page starts at once. If the LUN whose turn has come still reports busy, the scheduler holds before issuing anything and raises a sticky `overrun` flag. The outgoing bus is a simplified byte-wide bus. It has one-hot LUN selects and separate strobes for command, address and data, with one byte per cycle.

Top module: `lun_page_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, all strobes, `bus_ce`, `page_done`, `overrun` and `in_ready` are 0, and the first page goes to LUN 0 with in-LUN page 0.
- R2: Each page appears on the bus in this order:
  - one cycle with `bus_cmd`=1 and `bus_val`=0x80;
  - ADDR_CYCLES cycles with `bus_addr`=1;
  - PAGE_BYTES cycles with `bus_dat`=1;
  - one cycle with `bus_cmd`=1 and `bus_val`=0x10.
- R3: The address bytes carry the global page number (in-LUN page × NUM_LUNS + LUN index), least significant byte first. ADDR_CYCLES = ceil((PAGE_IDX_W + log2 NUM_LUNS)/8), which is 3 by default.
- R4: During every strobe `bus_ce` is one-hot on the target LUN. The target LUN advances by one (modulo NUM_LUNS) after each page. The in-LUN page number increments when the rotation wraps from the last LUN back to LUN 0.
- R5: `in_ready` is high only in the data phase. A byte is accepted on `in_valid && in_ready` and appears on `bus_val` with `bus_dat` in that same cycle. A cycle with `in_valid` low produces no data strobe and stalls the page.
- R6: `page_done` is a single-cycle pulse in the cycle right after the 0x10 program command.
- R7: No load-begin command is issued while the target LUN's `lun_busy` bit is high. Each cycle spent waiting on it sets `overrun`, which then stays 1 until reset. Busy bits of other LUNs have no effect.
- R8: At most one of `bus_cmd`, `bus_addr`, `bus_dat` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_req | input | 1 | Controller requests a page write (level, held until `page_done`) |
| page_done | output | 1 | One-cycle pulse after a page's program command |
| in_data | input | 8 | FIFO byte |
| in_valid | input | 1 | FIFO byte is valid |
| in_ready | output | 1 | Scheduler accepts a byte this cycle |
| lun_busy | input | NUM_LUNS | Per-LUN busy (programming) flags |
| bus_ce | output | NUM_LUNS | One-hot LUN select |
| bus_cmd | output | 1 | Command cycle strobe |
| bus_addr | output | 1 | Address cycle strobe |
| bus_dat | output | 1 | Data cycle strobe |
| bus_val | output | 8 | Byte on the bus |
| overrun | output | 1 | Sticky flag: target LUN was busy when its turn came |

## Verification
Two functions can land in the same cycle here. The first is the end of one page, where `page_done` fires and the rotation advances. The second is the acceptance of the next request, which happens when the controller keeps `page_req` high back-to-back. The bench drives long back-to-back runs, with and without FIFO gaps, across two full wraps of the rotation. A queue-based model predicts every command, address and data byte together with its LUN select, and the `page_done` pulse is compared every cycle. A second overlap comes from a LUN whose busy flag is still high when its turn arrives. The bench forces exactly that case and checks that no strobe appears while the LUN is held, that `overrun` rises one cycle after the wait begins and stays set, and that a busy flag on a non-target LUN changes nothing.

// File: rtl/lps_pkg.sv
// Shared types and bus op codes for the rotating LUN page write scheduler.
// Assumes a byte-wide command/address/data bus with separate strobes.
package lps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_PROG,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] OP_LOAD_BEGIN = 8'h80;
    localparam logic [7:0] OP_PROG_GO    = 8'h10;

endpackage

// File: rtl/lps_lun_rotator.sv
// Tracks the target LUN and the in-LUN page number, and forms the global
// page address. Advances once per completed page; the in-LUN page steps
// on each wrap back to LUN 0. Assumes NUM_LUNS >= 2.
module lps_lun_rotator #(
    parameter int NUM_LUNS   = 8,
    parameter int PAGE_IDX_W = 16,
    localparam int LUN_W     = (NUM_LUNS > 1) ? $clog2(NUM_LUNS) : 1,
    localparam int GA_W      = PAGE_IDX_W + LUN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance,
    output logic [NUM_LUNS-1:0]   lun_sel,
    output logic [GA_W-1:0]       page_addr
);

    logic [LUN_W-1:0]      lun_q;
    logic [PAGE_IDX_W-1:0] pg_q;

    // Step the rotation and, on wrap, the in-LUN page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lun_q <= '0;
            pg_q  <= '0;
        end else if (advance) begin
            if (lun_q == LUN_W'(NUM_LUNS - 1)) begin
                lun_q <= '0;
                pg_q  <= pg_q + PAGE_IDX_W'(1);
            end else begin
                lun_q <= lun_q + LUN_W'(1);
            end
        end
    end

    // One-hot decode of the target LUN.
    for (genvar g = 0; g < NUM_LUNS; g++) begin : g_sel
        assign lun_sel[g] = (lun_q == LUN_W'(g));
    end

    // Global page = in-LUN page * NUM_LUNS + LUN index.
    assign page_addr = (GA_W'(pg_q) * GA_W'(NUM_LUNS)) + GA_W'(lun_q);

endmodule

// File: rtl/lps_byte_counter.sv
// Counts payload bytes within a page and flags the final byte position.
// Assumes PAGE_BYTES >= 2.
module lps_byte_counter #(
    parameter int PAGE_BYTES = 8192,
    localparam int CNT_W     = $clog2(PAGE_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    logic [CNT_W-1:0] cnt_q;

    // Payload position within the current page.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign at_last = (cnt_q == CNT_W'(PAGE_BYTES - 1));

endmodule

// File: rtl/lps_addr_slicer.sv
// Splits the global page address into bus bytes, least significant first.
// Pure combinational; the index comes from the sequencer.
module lps_addr_slicer #(
    parameter int GA_W        = 19,
    parameter int ADDR_CYCLES = 3,
    parameter int AC_W        = 2
) (
    input  logic [GA_W-1:0] page_addr,
    input  logic [AC_W-1:0] idx,
    output logic [7:0]      addr_byte
);

    localparam int PAD_W = ADDR_CYCLES * 8;

    logic [PAD_W-1:0] padded;
    logic [7:0]       lanes [ADDR_CYCLES];

    assign padded = PAD_W'(page_addr);

    for (genvar g = 0; g < ADDR_CYCLES; g++) begin : g_lane
        assign lanes[g] = padded[g*8 +: 8];
    end

    // Select the lane for the current address cycle.
    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_CYCLES; k++) begin
            if (idx == AC_W'(k)) addr_byte = lanes[k];
        end
    end

endmodule

// File: rtl/lps_wr_sequencer.sv
// Per-page sequence: wait for request, wait for target LUN idle, load-begin
// command, address cycles, payload stream, program command, done pulse.
// Sets a sticky overrun flag for every cycle spent waiting on a busy target.
module lps_wr_sequencer
    import lps_pkg::*;
#(
    parameter int ADDR_CYCLES = 3,
    parameter int AC_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            page_req,
    input  logic            target_busy,
    input  logic            in_valid,
    input  logic            data_last,
    output logic            in_ready,
    output logic            cmd_stb,
    output logic            addr_stb,
    output logic            data_stb,
    output logic [7:0]      op_code,
    output logic [AC_W-1:0] addr_idx,
    output logic            lun_drive,
    output logic            cnt_clr,
    output logic            advance,
    output logic            page_done,
    output logic            overrun
);

    seq_state_t      st_q, st_d;
    logic [AC_W-1:0] acnt_q;
    logic            ovr_q;
    logic            addr_last;

    assign addr_last = (acnt_q == AC_W'(ADDR_CYCLES - 1));

    // Next-state selection for the page sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (page_req)               st_d = ST_ARM;
            ST_ARM:  if (!target_busy)           st_d = ST_CMD;
            ST_CMD:                              st_d = ST_ADDR;
            ST_ADDR: if (addr_last)              st_d = ST_DATA;
            ST_DATA: if (in_valid && data_last)  st_d = ST_PROG;
            ST_PROG:                             st_d = ST_DONE;
            ST_DONE:                             st_d = ST_IDLE;
            default:                             st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Address cycle index, restarted at every load-begin command.
    always_ff @(posedge clk) begin
        if (!rst_n)                acnt_q <= '0;
        else if (st_q == ST_CMD)   acnt_q <= '0;
        else if (st_q == ST_ADDR)  acnt_q <= acnt_q + AC_W'(1);
    end

    // Sticky overrun: target LUN busy when its turn came.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovr_q <= 1'b0;
        else if (st_q == ST_ARM && target_busy)   ovr_q <= 1'b1;
    end

    assign in_ready  = (st_q == ST_DATA);
    assign data_stb  = in_ready && in_valid;
    assign cmd_stb   = (st_q == ST_CMD) || (st_q == ST_PROG);
    assign op_code   = (st_q == ST_PROG) ? OP_PROG_GO : OP_LOAD_BEGIN;
    assign addr_stb  = (st_q == ST_ADDR);
    assign addr_idx  = acnt_q;
    assign lun_drive = cmd_stb || addr_stb || data_stb;
    assign cnt_clr   = (st_q == ST_CMD);
    assign advance   = (st_q == ST_DONE);
    assign page_done = (st_q == ST_DONE);
    assign overrun   = ovr_q;

endmodule

// File: rtl/lun_page_sched.sv
// Top of the rotating multi-LUN page write scheduler. Ties the rotation,
// the payload counter, the address slicer and the page sequencer to the
// FIFO stream, the controller handshake and the byte-wide flash bus.
// Assumes lun_busy is synchronous to clk.
module lun_page_sched #(
    parameter int NUM_LUNS   = 8,
    parameter int PAGE_BYTES = 8192,
    parameter int PAGE_IDX_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_req,
    output logic                page_done,
    input  logic [7:0]          in_data,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NUM_LUNS-1:0] lun_busy,
    output logic [NUM_LUNS-1:0] bus_ce,
    output logic                bus_cmd,
    output logic                bus_addr,
    output logic                bus_dat,
    output logic [7:0]          bus_val,
    output logic                overrun
);

    localparam int LUN_W       = (NUM_LUNS > 1) ? $clog2(NUM_LUNS) : 1;
    localparam int GA_W        = PAGE_IDX_W + LUN_W;
    localparam int ADDR_CYCLES = (GA_W + 7) / 8;
    localparam int AC_W        = (ADDR_CYCLES > 1) ? $clog2(ADDR_CYCLES) : 1;

    logic [NUM_LUNS-1:0] lun_sel;
    logic [GA_W-1:0]     page_addr;
    logic [AC_W-1:0]     addr_idx;
    logic [7:0]          addr_byte;
    logic [7:0]          op_code;
    logic                advance, cnt_clr, data_last, lun_drive;
    logic                cmd_stb, addr_stb, data_stb;
    logic                target_busy;

    lps_lun_rotator #(
        .NUM_LUNS   (NUM_LUNS),
        .PAGE_IDX_W (PAGE_IDX_W)
    ) rot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .lun_sel   (lun_sel),
        .page_addr (page_addr)
    );

    lps_byte_counter #(
        .PAGE_BYTES (PAGE_BYTES)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (data_stb),
        .at_last (data_last)
    );

    lps_addr_slicer #(
        .GA_W        (GA_W),
        .ADDR_CYCLES (ADDR_CYCLES),
        .AC_W        (AC_W)
    ) slc_i (
        .page_addr (page_addr),
        .idx       (addr_idx),
        .addr_byte (addr_byte)
    );

    lps_wr_sequencer #(
        .ADDR_CYCLES (ADDR_CYCLES),
        .AC_W        (AC_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_req    (page_req),
        .target_busy (target_busy),
        .in_valid    (in_valid),
        .data_last   (data_last),
        .in_ready    (in_ready),
        .cmd_stb     (cmd_stb),
        .addr_stb    (addr_stb),
        .data_stb    (data_stb),
        .op_code     (op_code),
        .addr_idx    (addr_idx),
        .lun_drive   (lun_drive),
        .cnt_clr     (cnt_clr),
        .advance     (advance),
        .page_done   (page_done),
        .overrun     (overrun)
    );

    // Only the LUN whose turn it is can hold the sequence.
    assign target_busy = |(lun_busy & lun_sel);

    assign bus_ce   = lun_drive ? lun_sel : '0;
    assign bus_cmd  = cmd_stb;
    assign bus_addr = addr_stb;
    assign bus_dat  = data_stb;

    // Bus byte mux: command, address or payload.
    always_comb begin
        bus_val = '0;
        if (cmd_stb)       bus_val = op_code;
        else if (addr_stb) bus_val = addr_byte;
        else if (data_stb) bus_val = in_data;
    end

endmodule

// File: rtl/lun_page_sched_chk.sv
// Protocol checker for lun_page_sched, attached by bind.
module lun_page_sched_chk
    import lps_pkg::*;
#(
    parameter int NUM_LUNS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                page_done,
    input logic [7:0]          in_data,
    input logic                in_valid,
    input logic                in_ready,
    input logic [NUM_LUNS-1:0] lun_busy,
    input logic [NUM_LUNS-1:0] bus_ce,
    input logic                bus_cmd,
    input logic                bus_addr,
    input logic                bus_dat,
    input logic [7:0]          bus_val,
    input logic                overrun
);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cmd, bus_addr, bus_dat}));

    p_ce_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd || bus_addr || bus_dat) |-> ($countones(bus_ce) == 1));

    p_data_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (bus_dat && bus_val == in_data));

    p_data_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dat |-> in_ready);

    p_done_after_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd && bus_val == OP_PROG_GO) |=> page_done);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd && bus_val == OP_LOAD_BEGIN) |-> (($past(lun_busy) & bus_ce) == '0));

endmodule

bind lun_page_sched lun_page_sched_chk #(.NUM_LUNS(NUM_LUNS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_done (page_done),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .lun_busy  (lun_busy),
    .bus_ce    (bus_ce),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_dat   (bus_dat),
    .bus_val   (bus_val),
    .overrun   (overrun)
);

// File: tb/lun_page_sched_tb_top.sv
// Bench: queue-based model of expected bus cycles, compared every clock.
module lun_page_sched_tb_top;

    localparam int NL    = 8;
    localparam int PB    = 16;
    localparam int PIW   = 16;
    localparam int AC    = 3;
    localparam int PROGC = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          page_req = 1'b0;
    logic          page_done;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [NL-1:0] lun_busy = '0;
    logic [NL-1:0] bus_ce;
    logic          bus_cmd, bus_addr, bus_dat;
    logic [7:0]    bus_val;
    logic          overrun;

    int qk[$];
    int qv[$];
    int ql[$];
    int vec = 0;
    int mis = 0;
    int exp_lun = 0;
    int exp_pg = 0;
    int pages_sent = 0;
    int busy_cnt [NL];
    logic [NL-1:0] force_busy = '0;
    bit exp_ovr = 0;
    bit prev_prog = 0;
    bit hold_off = 0;
    bit mon_en = 0;
    bit finished = 0;

    lun_page_sched #(
        .NUM_LUNS   (NL),
        .PAGE_BYTES (PB),
        .PAGE_IDX_W (PIW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_req  (page_req),
        .page_done (page_done),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .lun_busy  (lun_busy),
        .bus_ce    (bus_ce),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_dat   (bus_dat),
        .bus_val   (bus_val),
        .overrun   (overrun)
    );

    initial forever #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int dbyte(input int page, input int i);
        return (page * 37 + i * 11 + 5) & 255;
    endfunction

    // Expected bus cycles of one page, in order (R2, R3, R4).
    task automatic push_page();
        int ga;
        ga = exp_pg * NL + exp_lun;
        qk.push_back(0); qv.push_back(8'h80); ql.push_back(exp_lun);
        for (int k = 0; k < AC; k++) begin
            qk.push_back(1); qv.push_back((ga >> (8 * k)) & 255); ql.push_back(exp_lun);
        end
        for (int i = 0; i < PB; i++) begin
            qk.push_back(2); qv.push_back(dbyte(pages_sent, i)); ql.push_back(exp_lun);
        end
        qk.push_back(0); qv.push_back(8'h10); ql.push_back(exp_lun);
        if (exp_lun == NL - 1) begin
            exp_lun = 0;
            exp_pg++;
        end else begin
            exp_lun++;
        end
    endtask

    task automatic send_bytes(input bit gap);
        for (int i = 0; i < PB; i++) begin
            if (gap && (i % 5 == 2)) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = 8'(dbyte(pages_sent, i));
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        pages_sent++;
    endtask

    task automatic run_pages(input int n, input bit gap);
        for (int p = 0; p < n; p++) begin
            push_page();
            page_req = 1'b1;
            send_bytes(gap);
            do @(negedge clk); while (!page_done);
            @(posedge clk); #1;
            if (p == n - 1) page_req = 1'b0;
        end
    endtask

    // LUN programming emulation: busy for PROGC cycles after a program command.
    initial begin
        for (int i = 0; i < NL; i++) busy_cnt[i] = 0;
        forever begin
            @(posedge clk); #2;
            for (int i = 0; i < NL; i++) begin
                if (busy_cnt[i] > 0) busy_cnt[i]--;
                lun_busy[i] = (busy_cnt[i] > 0) || force_busy[i];
            end
        end
    end

    // Cycle-by-cycle comparison against the expected queue.
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R8 single strobe", 32'($countones({bus_cmd, bus_addr, bus_dat}) <= 1), 1);
            if (!in_valid) chk("R5 no data strobe without valid", 32'(bus_dat), 0);
            if (bus_cmd || bus_addr || bus_dat) begin
                if (hold_off) chk("R7 strobe while target busy", 1, 0);
                if (qk.size() == 0) begin
                    chk("R2 unexpected strobe", 1, 0);
                end else begin
                    int k, v, l;
                    k = qk.pop_front(); v = qv.pop_front(); l = ql.pop_front();
                    chk("R2 cycle kind", bus_cmd ? 0 : (bus_addr ? 1 : 2), 32'(k));
                    chk("R3 bus byte", 32'(bus_val), 32'(v));
                    chk("R4 LUN select", 32'(bus_ce), 32'(1) << l);
                    if (bus_dat) chk("R5 ready with data", 32'(in_ready), 1);
                    if (bus_cmd && bus_val == 8'h10) busy_cnt[l] = PROGC;
                end
            end
            chk("R6 page_done timing", 32'(page_done), 32'(prev_prog));
            prev_prog = bus_cmd && (bus_val == 8'h10);
            chk("R7 overrun flag", 32'(overrun), 32'(exp_ovr));
        end
    end

    initial begin
        #(20000 * 10);
        if (!finished) begin
            mis++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", 32'({bus_cmd, bus_addr, bus_dat}), 0);
        chk("R1 bus_ce in reset", 32'(bus_ce), 0);
        chk("R1 page_done in reset", 32'(page_done), 0);
        chk("R1 overrun in reset", 32'(overrun), 0);
        chk("R1 in_ready in reset", 32'(in_ready), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'({bus_cmd, bus_addr, bus_dat, in_ready}), 0);
        @(posedge clk); #1;

        // R2 R3 R4 R6: back-to-back pages across a rotation wrap
        run_pages(10, 1'b0);
        // R5: FIFO gaps stall the stream
        run_pages(3, 1'b1);

        // R7: busy flag on a non-target LUN is ignored
        force_busy[(exp_lun + 4) % NL] = 1'b1;
        run_pages(1, 1'b1);
        force_busy = '0;
        repeat (2) @(posedge clk); #1;

        // R7: target LUN busy at its turn holds the page and sets overrun
        force_busy[exp_lun] = 1'b1;
        @(posedge clk); #1;
        push_page();
        hold_off = 1'b1;
        page_req = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        exp_ovr = 1'b1;
        repeat (5) @(posedge clk); #1;
        force_busy = '0;
        hold_off = 1'b0;
        send_bytes(1'b0);
        do @(negedge clk); while (!page_done);
        @(posedge clk); #1;
        page_req = 1'b0;

        // R7: overrun stays set over later pages
        run_pages(5, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 expected queue drained", 32'(qk.size()), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule